// File: doc/BRIEF.md
# Link Port Buffer Credit and Ingress Hold Timer

This block keeps the flow-control accounting for one end of a credit-based serial link. On the send side it holds the number of frames the peer can still accept. That number is loaded from the buffer count the peer advertises when the link is brought up. Each frame sent uses one credit, and each ready primitive that comes back returns one. Sending stops while the count is zero. The two directions of a link are independent, so the local advertisement and the peer's advertisement may differ.

On the receive side the block tracks a small set of local ingress buffer slots. An arriving frame takes the lowest free slot. The slot is released when the forwarding logic takes the frame out. If the frame sits longer than the hold time, it is thrown away instead. Either way the slot is freed and one ready primitive is queued back to the sender.

The hold time depends on the port's role:
- Inter-switch ports always use a default computed from the fabric timeouts and the hop limit: half of (RA - ED) / (hops + 1), which is 500 ms with the default parameters.
- Device-facing ports may use a shorter configured value.
- Under the per-group policy, any group that contains an inter-switch port falls back to the default on all of its ports.

Two saturating statistics are kept: the number of cycles spent at zero credit, and the number of discarded frames.

Top module: `cbp_port`

## Requirements
- R1: A cycle with `login_vld` high loads both the credit count and the credit ceiling with `peer_bufs`. The new count is visible on `credit` after that clock edge. Before the first login, credit is 0.
- R2: When `tx_req` is high and `credit` is nonzero, `tx_allow` is high, a frame is taken and credit drops by one. At zero credit, `tx_allow` is low and `tx_req` leaves credit at zero.
- R3: Each `rdy_in` pulse received below the ceiling raises credit by one. When a send and a ready coincide, credit is unchanged.
- R4: A `rdy_in` that arrives while credit equals the ceiling, or before any login, is ignored and credit is unchanged. In that case `proto_err` is high for the one cycle after it.
- R5: An `rx_frame` pulse occupies the lowest-numbered free slot, whose bit in `slot_busy` (bit i = slot i) is set after the edge. When all slots are busy, the pulse changes nothing.
- R6: `fwd_vld` with a busy `fwd_slot` frees that slot. A request naming a free slot changes nothing. When a forward and an expiry hit the same slot in the same cycle, the forward wins and no discard is counted.
- R7: A slot's age is cleared on arrival and advances on each `tick_ms` while the slot is busy. On the tick that would bring the age to `hold_ms`, the slot is freed, `discard` is high for one cycle and `discard_cnt` grows by the number of slots dropped on that tick.
- R8: The default hold is ((RA_MS - ED_MS)/(MAX_HOPS+1))/2, which is 500 with the default parameters. A port with `is_isl` high always uses it.
- R9: With `role_policy` = 1 (per role), a device port uses `cfg_edge_ms` clamped to the range [MIN_EDGE_MS = 100, default].
- R10: With `role_policy` = 0 (per group), a device port whose `group_has_isl` is high uses the default. Otherwise it uses the clamped configured value.
- R11: Every slot freed, by forward or by discard, yields exactly one `rdy_out` cycle. At most one is sent per cycle, and the first is sent in the cycle after the edge that freed the slot.
- R12: After login, `zero_cnt` grows by one for every clock edge at which credit is zero. Both statistics stop at their all-ones value and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| login_vld | input | 1 | Load credit from peer advertisement |
| peer_bufs | input | CRED_W | Peer's advertised receive buffer count |
| tx_req | input | 1 | Frame waiting to be sent |
| tx_allow | output | 1 | Send permitted (credit nonzero) |
| rdy_in | input | 1 | Ready primitive received from peer |
| credit | output | CRED_W | Current send credit |
| proto_err | output | 1 | Excess ready primitive seen |
| rx_frame | input | 1 | Frame arrived into local ingress |
| fwd_vld | input | 1 | Forwarding logic removes a frame |
| fwd_slot | input | SLOT_W | Slot being forwarded |
| slot_busy | output | NSLOT | Occupied slots, bit i = slot i |
| tick_ms | input | 1 | Millisecond tick |
| is_isl | input | 1 | Port is an inter-switch port |
| group_has_isl | input | 1 | Port group contains an inter-switch port |
| role_policy | input | 1 | 1 = per-role hold policy, 0 = per-group |
| cfg_edge_ms | input | HOLD_W | Configured device-port hold time |
| hold_ms | output | HOLD_W | Effective hold time in use |
| discard | output | 1 | One or more frames dropped last edge |
| rdy_out | output | 1 | Send one ready primitive to the peer |
| zero_cnt | output | STAT_W | Cycles spent at zero credit |
| discard_cnt | output | STAT_W | Frames discarded |

## Verification
Some rules are checked by assertions on every cycle:
- credit never exceeds its ceiling, and stays at zero unless a ready arrives;
- an excess ready leaves credit unchanged;
- the effective hold time always lies within its clamp;
- a freed slot always produces a pending ready;
- the statistics never wrap.

Other behaviour can only be shown by the bench's scenarios:
- the exact cycle on which a slot expires;
- lowest-free slot allocation and the ignored arrival into a full buffer;
- the hold value chosen for each role and policy combination;
- the count of ready primitives sent after several slots expire together.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef enum logic {
    POL_GROUP = 1'b0,
    POL_ROLE  = 1'b1
  } hold_policy_e;

  function automatic int unsigned default_hold(input int unsigned ra_ms,
                                               input int unsigned ed_ms,
                                               input int unsigned hops);
    return ((ra_ms - ed_ms) / (hops + 1)) / 2;
  endfunction
endpackage

// File: rtl/cbp_hold_sel.sv
module cbp_hold_sel
  import cbp_pkg::*;
#(
  parameter int unsigned HOLD_W      = 16,
  parameter int unsigned RA_MS       = 10000,
  parameter int unsigned ED_MS       = 2000,
  parameter int unsigned MAX_HOPS    = 7,
  parameter int unsigned MIN_EDGE_MS = 100
) (
  input  logic              is_isl,
  input  logic              group_has_isl,
  input  logic              role_policy,
  input  logic [HOLD_W-1:0] cfg_edge_ms,
  output logic [HOLD_W-1:0] hold_ms
);
  localparam int unsigned DEF_MS = default_hold(RA_MS, ED_MS, MAX_HOPS);
  localparam logic [HOLD_W-1:0] DEF_V = HOLD_W'(DEF_MS);
  localparam logic [HOLD_W-1:0] MIN_V = HOLD_W'(MIN_EDGE_MS);

  hold_policy_e pol;
  logic         use_def;
  logic [HOLD_W-1:0] edge_v;

  always_comb begin
    pol     = hold_policy_e'(role_policy);
    use_def = is_isl || ((pol == POL_GROUP) && group_has_isl);
    if (cfg_edge_ms < MIN_V)      edge_v = MIN_V;
    else if (cfg_edge_ms > DEF_V) edge_v = DEF_V;
    else                          edge_v = cfg_edge_ms;
    hold_ms = use_def ? DEF_V : edge_v;
  end

  // R9: the effective hold always lies inside the clamp window
  always_comb begin
    p_hold_window_r9: assert (hold_ms >= MIN_V && hold_ms <= DEF_V);
  end
endmodule

// File: rtl/cbp_tx_credit.sv
module cbp_tx_credit #(
  parameter int unsigned CRED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              login_vld,
  input  logic [CRED_W-1:0] peer_bufs,
  input  logic              tx_req,
  input  logic              rdy_in,
  output logic              tx_allow,
  output logic [CRED_W-1:0] credit,
  output logic              proto_err,
  output logic              logged_in,
  output logic              at_zero
);
  logic [CRED_W-1:0] cred_q, cred_d, cmax_q, cmax_d;
  logic              log_q, log_d, err_q, err_d;
  logic              send, rdy_ok;

  always_comb begin
    send   = tx_req && (cred_q != '0);
    rdy_ok = rdy_in && log_q && (cred_q != cmax_q);
    err_d  = rdy_in && !login_vld && !rdy_ok;
    cmax_d = cmax_q;
    log_d  = log_q;
    cred_d = cred_q;
    if (login_vld) begin
      cmax_d = peer_bufs;
      cred_d = peer_bufs;
      log_d  = 1'b1;
    end else begin
      if (send && !rdy_ok)      cred_d = cred_q - 1'b1;
      else if (rdy_ok && !send) cred_d = cred_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q <= '0;
      cmax_q <= '0;
      log_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cred_q <= cred_d;
      cmax_q <= cmax_d;
      log_q  <= log_d;
      err_q  <= err_d;
    end
  end

  assign tx_allow  = (cred_q != '0);
  assign credit    = cred_q;
  assign proto_err = err_q;
  assign logged_in = log_q;
  assign at_zero   = log_q && (cred_q == '0);

  p_credit_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cred_q <= cmax_q);

  p_hold_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_q == '0 && !rdy_in && !login_vld) |=> (cred_q == '0));

  p_excess_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q && cred_q == cmax_q && rdy_in && !tx_req && !login_vld)
      |=> ($stable(cred_q) && err_q));
endmodule

// File: rtl/cbp_rx_slots.sv
module cbp_rx_slots #(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned HOLD_W = 16,
  parameter int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  parameter int unsigned CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_frame,
  input  logic              fwd_vld,
  input  logic [SLOT_W-1:0] fwd_slot,
  input  logic              tick_ms,
  input  logic [HOLD_W-1:0] hold_ms,
  output logic [NSLOT-1:0]  slot_busy,
  output logic [CNT_W-1:0]  free_cnt,
  output logic [CNT_W-1:0]  drop_cnt
);
  logic [NSLOT-1:0]  busy_q, busy_d, alloc, expire, fwd_hit, freed, dropped;
  logic [HOLD_W-1:0] age_q [NSLOT];
  logic [HOLD_W-1:0] age_d [NSLOT];
  logic              found;

  always_comb begin
    alloc = '0;
    found = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rx_frame && !busy_q[i] && !found) begin
        alloc[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_comb begin
      expire[g]  = busy_q[g] && tick_ms &&
                   ({1'b0, age_q[g]} + 1'b1 >= {1'b0, hold_ms});
      fwd_hit[g] = fwd_vld && (fwd_slot == SLOT_W'(g)) && busy_q[g];
      freed[g]   = expire[g] || fwd_hit[g];
      dropped[g] = expire[g] && !fwd_hit[g];
      if (alloc[g])
        age_d[g] = '0;
      else if (busy_q[g] && tick_ms && !freed[g])
        age_d[g] = age_q[g] + 1'b1;
      else
        age_d[g] = age_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        age_q[g] <= '0;
      else if (alloc[g] || (busy_q[g] && tick_ms))
        age_q[g] <= age_d[g];
    end

    p_age_below_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[g] && tick_ms && age_q[g] + 1'b1 >= hold_ms) |=> !busy_q[g]);
  end

  always_comb begin
    busy_d   = (busy_q & ~freed) | alloc;
    free_cnt = CNT_W'($countones(freed));
    drop_cnt = CNT_W'($countones(dropped));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign slot_busy = busy_q;

  p_full_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_q && !fwd_vld && !tick_ms) |=> (&busy_q));

  p_one_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc));
endmodule

// File: rtl/cbp_sat_ctr.sv
module cbp_sat_ctr #(
  parameter int unsigned W     = 32,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     count
);
  localparam logic [W:0] TOP = {1'b0, {W{1'b1}}};
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + (W + 1)'(inc);
    cnt_d = (sum > TOP) ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (inc != '0)  cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_q) |=> (&cnt_q));
endmodule

// File: rtl/cbp_port.sv
module cbp_port
  import cbp_pkg::*;
#(
  parameter int unsigned CRED_W      = 8,
  parameter int unsigned NSLOT       = 4,
  parameter int unsigned HOLD_W      = 16,
  parameter int unsigned STAT_W      = 32,
  parameter int unsigned RA_MS       = 10000,
  parameter int unsigned ED_MS       = 2000,
  parameter int unsigned MAX_HOPS    = 7,
  parameter int unsigned MIN_EDGE_MS = 100,
  parameter int unsigned SLOT_W      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              login_vld,
  input  logic [CRED_W-1:0] peer_bufs,
  input  logic              tx_req,
  output logic              tx_allow,
  input  logic              rdy_in,
  output logic [CRED_W-1:0] credit,
  output logic              proto_err,
  input  logic              rx_frame,
  input  logic              fwd_vld,
  input  logic [SLOT_W-1:0] fwd_slot,
  output logic [NSLOT-1:0]  slot_busy,
  input  logic              tick_ms,
  input  logic              is_isl,
  input  logic              group_has_isl,
  input  logic              role_policy,
  input  logic [HOLD_W-1:0] cfg_edge_ms,
  output logic [HOLD_W-1:0] hold_ms,
  output logic              discard,
  output logic              rdy_out,
  output logic [STAT_W-1:0] zero_cnt,
  output logic [STAT_W-1:0] discard_cnt
);
  localparam int unsigned CNT_W  = $clog2(NSLOT + 1);
  localparam int unsigned PEND_W = $clog2(4 * NSLOT + 4);

  logic             logged_in, at_zero;
  logic [CNT_W-1:0] free_cnt, drop_cnt;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PEND_W:0]   pend_sum;
  logic             disc_q;

  cbp_hold_sel #(
    .HOLD_W(HOLD_W), .RA_MS(RA_MS), .ED_MS(ED_MS),
    .MAX_HOPS(MAX_HOPS), .MIN_EDGE_MS(MIN_EDGE_MS)
  ) u_hold (
    .is_isl(is_isl), .group_has_isl(group_has_isl),
    .role_policy(role_policy), .cfg_edge_ms(cfg_edge_ms), .hold_ms(hold_ms)
  );

  cbp_tx_credit #(.CRED_W(CRED_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .login_vld(login_vld), .peer_bufs(peer_bufs),
    .tx_req(tx_req), .rdy_in(rdy_in), .tx_allow(tx_allow), .credit(credit),
    .proto_err(proto_err), .logged_in(logged_in), .at_zero(at_zero)
  );

  cbp_rx_slots #(.NSLOT(NSLOT), .HOLD_W(HOLD_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_frame(rx_frame), .fwd_vld(fwd_vld),
    .fwd_slot(fwd_slot), .tick_ms(tick_ms), .hold_ms(hold_ms),
    .slot_busy(slot_busy), .free_cnt(free_cnt), .drop_cnt(drop_cnt)
  );

  cbp_sat_ctr #(.W(STAT_W), .INC_W(1)) u_zero (
    .clk(clk), .rst_n(rst_n), .inc(at_zero), .count(zero_cnt)
  );

  cbp_sat_ctr #(.W(STAT_W), .INC_W(CNT_W)) u_disc (
    .clk(clk), .rst_n(rst_n), .inc(drop_cnt), .count(discard_cnt)
  );

  // pending ready primitives: one leaves per cycle, every freed slot adds one
  always_comb begin
    pend_sum = {1'b0, pend_q} + (PEND_W + 1)'(free_cnt) - (PEND_W + 1)'(pend_q != '0);
    pend_d   = pend_sum[PEND_W] ? {PEND_W{1'b1}} : pend_sum[PEND_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      disc_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      disc_q <= (drop_cnt != '0);
    end
  end

  assign rdy_out = (pend_q != '0);
  assign discard = disc_q;

  p_free_queues_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt != '0) |=> rdy_out);

  p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != '0) |=> (discard && rdy_out));
endmodule

// File: tb/sim_cbp_port.sv
module sim_cbp_port;
  localparam int CRED_W = 8, NSLOT = 4, HOLD_W = 16, STAT_W = 32;
  localparam int DEF_HOLD = ((10000 - 2000) / (7 + 1)) / 2;
  localparam int MIN_HOLD = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic login_vld = 0, tx_req = 0, rdy_in = 0, rx_frame = 0, fwd_vld = 0, tick_ms = 0;
  logic is_isl = 0, group_has_isl = 0, role_policy = 1;
  logic [CRED_W-1:0] peer_bufs = '0;
  logic [1:0]        fwd_slot = '0;
  logic [HOLD_W-1:0] cfg_edge_ms = 16'd150;
  logic tx_allow, proto_err, discard, rdy_out;
  logic [CRED_W-1:0] credit;
  logic [NSLOT-1:0]  slot_busy;
  logic [HOLD_W-1:0] hold_ms;
  logic [STAT_W-1:0] zero_cnt, discard_cnt;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cbp_port u0 (
    .clk(clk), .rst_n(rst_n), .login_vld(login_vld), .peer_bufs(peer_bufs),
    .tx_req(tx_req), .tx_allow(tx_allow), .rdy_in(rdy_in), .credit(credit),
    .proto_err(proto_err), .rx_frame(rx_frame), .fwd_vld(fwd_vld),
    .fwd_slot(fwd_slot), .slot_busy(slot_busy), .tick_ms(tick_ms),
    .is_isl(is_isl), .group_has_isl(group_has_isl), .role_policy(role_policy),
    .cfg_edge_ms(cfg_edge_ms), .hold_ms(hold_ms), .discard(discard),
    .rdy_out(rdy_out), .zero_cnt(zero_cnt), .discard_cnt(discard_cnt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic hold_case(input bit isl, input bit grp, input bit pol,
                           input int cfg, input string req);
    int exp;
    is_isl = isl; group_has_isl = grp; role_policy = pol; cfg_edge_ms = HOLD_W'(cfg);
    #1;
    if (isl || (!pol && grp)) exp = DEF_HOLD;
    else exp = (cfg < MIN_HOLD) ? MIN_HOLD : (cfg > DEF_HOLD) ? DEF_HOLD : cfg;
    check(hold_ms == HOLD_W'(exp), req, hold_ms, exp);
  endtask

  initial begin
    int exp_cred, z0, d0, pulses;
    #1;
    step();
    check(credit == 0 && !tx_allow && slot_busy == 0 && !rdy_out, "R1 reset", credit, 0);
    check(zero_cnt == 0 && discard_cnt == 0, "R12 reset", zero_cnt, 0);
    rst_n = 1'b1;
    step();

    // R4: ready before login is ignored and flagged
    rdy_in = 1; step(); rdy_in = 0;
    check(credit == 0, "R4 pre-login", credit, 0);
    check(proto_err == 1, "R4 pre-login err", proto_err, 1);

    // sweep two asymmetric advertisements
    for (int a = 0; a < 2; a++) begin
      int adv = (a == 0) ? 3 : 8;
      login_vld = 1; peer_bufs = CRED_W'(adv); step(); login_vld = 0;
      check(credit == CRED_W'(adv), "R1 login", credit, adv);
      exp_cred = adv;
      tx_req = 1;
      for (int k = 0; k < adv + 2; k++) begin
        check(tx_allow == (exp_cred != 0), "R2 allow", tx_allow, exp_cred != 0);
        step();
        if (exp_cred > 0) exp_cred--;
        check(credit == CRED_W'(exp_cred), "R2 decrement", credit, exp_cred);
      end
      tx_req = 0;
      z0 = int'(zero_cnt);
      repeat (10) step();
      check(int'(zero_cnt) - z0 == 10, "R12 zero cycles", int'(zero_cnt) - z0, 10);
      for (int k = 0; k < adv; k++) begin
        rdy_in = 1; step(); rdy_in = 0;
        check(credit == CRED_W'(k + 1), "R3 replenish", credit, k + 1);
      end
      rdy_in = 1; step(); rdy_in = 0;
      check(credit == CRED_W'(adv), "R4 excess ignored", credit, adv);
      check(proto_err == 1, "R4 excess flagged", proto_err, 1);
      step();
      check(proto_err == 0, "R4 single pulse", proto_err, 0);
      tx_req = 1; rdy_in = 1; step(); tx_req = 0; rdy_in = 0;
      check(credit == CRED_W'(adv - 1), "R3 send with excess ready", credit, adv - 1);
      tx_req = 1; rdy_in = 1; step(); tx_req = 0; rdy_in = 0;
      check(credit == CRED_W'(adv - 1), "R3 send plus ready", credit, adv - 1);
    end

    // hold time selection sweep
    for (int c = 0; c < 4; c++) begin
      int cfg = (c == 0) ? 50 : (c == 1) ? 150 : (c == 2) ? 220 : 900;
      for (int m = 0; m < 8; m++)
        hold_case(m[0], m[1], m[2], cfg, m[0] ? "R8 isl default" :
                  (m[2] ? "R9 role policy" : "R10 group policy"));
    end
    check(DEF_HOLD == 500, "R8 formula", DEF_HOLD, 500);

    // receive slots: fill, overfill, forward
    is_isl = 0; group_has_isl = 0; role_policy = 1; cfg_edge_ms = 16'd50;
    for (int k = 0; k < NSLOT; k++) begin
      rx_frame = 1; step(); rx_frame = 0;
      check(slot_busy == NSLOT'((1 << (k + 1)) - 1), "R5 lowest free", slot_busy, (1 << (k + 1)) - 1);
    end
    rx_frame = 1; step(); rx_frame = 0;
    check(slot_busy == 4'hF, "R5 full ignored", slot_busy, 15);
    check(!rdy_out, "R5 no ready when full", rdy_out, 0);
    fwd_vld = 1; fwd_slot = 2'd2; step(); fwd_vld = 0;
    check(slot_busy == 4'hB, "R6 forward frees", slot_busy, 11);
    check(rdy_out == 1, "R11 ready after forward", rdy_out, 1);
    step();
    check(rdy_out == 0, "R11 single ready", rdy_out, 0);
    fwd_vld = 1; fwd_slot = 2'd2; step(); fwd_vld = 0;
    check(slot_busy == 4'hB && !rdy_out, "R6 free slot forward ignored", slot_busy, 11);
    rx_frame = 1; step(); rx_frame = 0;
    check(slot_busy == 4'hF, "R5 refill slot 2", slot_busy, 15);
    fwd_vld = 1; fwd_slot = 2'd3; step(); fwd_vld = 0;
    step();

    // expiry: three busy slots, hold clamped to 100
    d0 = int'(discard_cnt);
    tick_ms = 1;
    for (int k = 0; k < MIN_HOLD - 1; k++) step();
    check(slot_busy == 4'h7, "R7 not yet expired", slot_busy, 7);
    step();
    tick_ms = 0;
    check(slot_busy == 4'h0, "R7 expired on hold tick", slot_busy, 0);
    check(discard == 1, "R7 discard pulse", discard, 1);
    check(int'(discard_cnt) - d0 == 3, "R7 discard count", int'(discard_cnt) - d0, 3);
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      if (rdy_out) pulses++;
      step();
    end
    check(pulses == 3, "R11 one ready per expired slot", pulses, 3);
    check(discard == 0, "R7 discard single", discard, 0);

    // forward beats expiry in the same cycle
    rx_frame = 1; step(); rx_frame = 0;
    d0 = int'(discard_cnt);
    tick_ms = 1;
    for (int k = 0; k < MIN_HOLD - 1; k++) step();
    fwd_vld = 1; fwd_slot = 2'd0; step(); fwd_vld = 0; tick_ms = 0;
    check(slot_busy == 0 && discard == 0, "R6 forward wins", slot_busy, 0);
    check(int'(discard_cnt) == d0, "R6 no discard counted", discard_cnt, d0);
    check(rdy_out == 1, "R11 ready after forward", rdy_out, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule